// File: doc/BRIEF.md
# Card Interface Power-State Controller

This block sequences the power state of a memory-card host interface. Software writes a 2-bit state code and a direction-polarity flag. The controller then decides whether the card clock runs. It also decides whether the controller itself holds the clock, command and data pads, and at which static level it holds them. A readback word reports the current state code and the polarity flag.

The block has five named states. The states are RESET (after a synchronous reset), OFF, CYCLE, WARM and ON. Writing the on code from RESET, OFF or CYCLE enters WARM. In WARM the card clock runs but the host stays disabled. The pads stay held idle until a fixed number of card clock periods have gone by, as counted on `card_tick`. WARM then moves to ON by itself, and `host_ready` rises.

The transitions are:
- RESET→OFF, RESET→CYCLE and RESET→WARM by write.
- OFF→CYCLE, OFF→WARM, CYCLE→OFF and CYCLE→WARM by write.
- WARM→ON when the tick count completes.
- WARM→OFF, WARM→CYCLE, ON→OFF and ON→CYCLE by write.
- Any state to RESET on `rst`.

Software is expected to step RESET, then CYCLE, then OFF, then ON. The block nevertheless accepts any valid code from any state.

Top module: `card_pwr_ctrl`

## Requirements
- R1: `ctl_code` encodes 2'b00 = off, 2'b10 = power-cycle and 2'b11 = on. `rd_data[1:0]` reads back 00 in RESET and OFF, 10 in CYCLE, and 11 in WARM and ON. `rd_data[4]` holds the polarity flag, and all other readback bits are 0.
- R2: While `rst` is high at a clock edge, the block enters RESET. In RESET, `rd_data` is 0, every pad level (clock, command, all data) is 0, `pad_hold` is 1, `card_clk_en` is 0 and `host_ready` is 0.
- R3: In CYCLE, the clock, command and every data pad level are 0, `pad_hold` is 1, and the card clock is gated off.
- R4: In OFF, the clock, command and every data pad level are 1, `pad_hold` is 1, the card clock is gated off, and `host_ready` is 0.
- R5: A write of the on code from RESET, OFF or CYCLE enters WARM. In WARM, `card_clk_en` is 1, `pad_hold` is 1, the command and data levels are 1, the clock level is 0, and `host_ready` is 0.
- R6: WARM moves to ON at the edge that samples the WARM_CYCLES-th `card_tick` counted since entry. From the following cycle, `host_ready` is 1 and `pad_hold` is 0. A write of the on code in WARM or ON neither restarts nor shortens the count.
- R7: A write with `ctl_code` = 2'b01 is ignored: both the state and the polarity flag keep their previous values.
- R8: `dir_cmd` equals `cmd_dir_req` XOR the polarity flag in ON, and equals NOT of the polarity flag in every other state. `dir_dat` behaves the same way with `dat_dir_req`.
- R9: A write of 00 or 10 takes effect at its edge, whatever the state. This holds in WARM even when a tick arrives at the same edge, and the write wins. After that edge, `host_ready` and `card_clk_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_code | input | 2 | State code to write |
| ctl_pol | input | 1 | Direction-polarity flag to write |
| card_tick | input | 1 | One pulse per card clock period |
| cmd_dir_req | input | 1 | Command-line direction wanted by the command path (1 = host drives) |
| dat_dir_req | input | 1 | Data-line direction wanted by the data path (1 = host drives) |
| rd_data | output | 8 | Readback: state code in [1:0], polarity in [4] |
| card_clk_en | output | 1 | Card clock gate enable |
| pad_hold | output | 1 | Controller overrides the card pads with static levels |
| pad_clk_lvl | output | 1 | Static clock pad level while held |
| pad_cmd_lvl | output | 1 | Static command pad level while held |
| pad_dat_lvl | output | NDAT | Static data pad levels while held |
| host_ready | output | 1 | Host enabled, warm-up window complete |
| dir_cmd | output | 1 | Level-shifter direction for command line |
| dir_dat | output | 1 | Level-shifter direction for data lines |

## Verification
The bench builds the block with its defaults: eight data lanes and a 74-tick warm-up window. This means the full-width data pad levels and the exact warm-up length are compared as they would be in use. Ticks are driven both every cycle and every third cycle, which brings two situations within reach. The first is a write and a tick landing on the same edge. The second is an abort or a reserved write partway through the window. An on write during warm-up or on is exercised too.

// File: rtl/cpwr_pkg.sv
package cpwr_pkg;

    typedef enum logic [2:0] {
        PS_RESET = 3'd0,
        PS_OFF   = 3'd1,
        PS_CYCLE = 3'd2,
        PS_WARM  = 3'd3,
        PS_ON    = 3'd4
    } pstate_e;

    localparam logic [1:0] CODE_OFF   = 2'b00;
    localparam logic [1:0] CODE_RSVD  = 2'b01;
    localparam logic [1:0] CODE_CYCLE = 2'b10;
    localparam logic [1:0] CODE_ON    = 2'b11;

    localparam int RD_W    = 8;
    localparam int POL_BIT = 4;

    // target state of a valid write; the on code lands in warm-up
    function automatic pstate_e target_of(input logic [1:0] code);
        pstate_e t;
        unique case (code)
            CODE_OFF:   t = PS_OFF;
            CODE_CYCLE: t = PS_CYCLE;
            default:    t = PS_WARM;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/cpwr_warm_timer.sv
module cpwr_warm_timer #(
    parameter int WARM_CYCLES = 74
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == LAST);

endmodule

// File: rtl/cpwr_state_fsm.sv
module cpwr_state_fsm
    import cpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_code,
    input  logic       ctl_pol,
    input  logic       warm_done,
    output pstate_e    state,
    output logic       pol
);
    pstate_e nxt;
    logic    pol_nxt;
    logic    wr_ok;

    assign wr_ok = ctl_wr && (ctl_code != CODE_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_RESET;
            pol   <= 1'b0;
        end else begin
            state <= nxt;
            pol   <= pol_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        pol_nxt = wr_ok ? ctl_pol : pol;
        unique case (state)
            PS_RESET, PS_OFF, PS_CYCLE: begin
                if (wr_ok) begin
                    nxt = target_of(ctl_code);
                end
            end
            PS_WARM: begin
                if (wr_ok && ctl_code != CODE_ON) begin
                    nxt = target_of(ctl_code);
                end else if (warm_done) begin
                    nxt = PS_ON;
                end
            end
            PS_ON: begin
                if (wr_ok && ctl_code != CODE_ON) begin
                    nxt = target_of(ctl_code);
                end
            end
            default: nxt = PS_RESET;
        endcase
    end

endmodule

// File: rtl/cpwr_pad_drive.sv
module cpwr_pad_drive
    import cpwr_pkg::*;
#(
    parameter int NDAT = 8
) (
    input  pstate_e         state,
    input  logic            pol,
    input  logic            cmd_dir_req,
    input  logic            dat_dir_req,
    output logic [1:0]      code,
    output logic            card_clk_en,
    output logic            pad_hold,
    output logic            pad_clk_lvl,
    output logic            pad_cmd_lvl,
    output logic [NDAT-1:0] pad_dat_lvl,
    output logic            host_ready,
    output logic            dir_cmd,
    output logic            dir_dat
);
    logic idle_lvl;
    logic cmd_out, dat_out;

    always_comb begin
        code        = CODE_OFF;
        card_clk_en = 1'b0;
        pad_hold    = 1'b1;
        pad_clk_lvl = 1'b0;
        idle_lvl    = 1'b0;
        host_ready  = 1'b0;
        cmd_out     = 1'b1;
        dat_out     = 1'b1;
        unique case (state)
            PS_RESET: begin
                code = CODE_OFF;
            end
            PS_OFF: begin
                code        = CODE_OFF;
                pad_clk_lvl = 1'b1;
                idle_lvl    = 1'b1;
            end
            PS_CYCLE: begin
                code = CODE_CYCLE;
            end
            PS_WARM: begin
                code        = CODE_ON;
                card_clk_en = 1'b1;
                idle_lvl    = 1'b1;
            end
            PS_ON: begin
                code        = CODE_ON;
                card_clk_en = 1'b1;
                pad_hold    = 1'b0;
                idle_lvl    = 1'b1;
                host_ready  = 1'b1;
                cmd_out     = cmd_dir_req;
                dat_out     = dat_dir_req;
            end
            default: begin
                code = CODE_OFF;
            end
        endcase
    end

    assign pad_cmd_lvl = idle_lvl;

    for (genvar g = 0; g < NDAT; g++) begin : g_lane
        assign pad_dat_lvl[g] = idle_lvl;
    end

    assign dir_cmd = cmd_out ^ pol;
    assign dir_dat = dat_out ^ pol;

endmodule

// File: rtl/card_pwr_ctrl.sv
module card_pwr_ctrl
    import cpwr_pkg::*;
#(
    parameter int NDAT        = 8,
    parameter int WARM_CYCLES = 74
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_wr,
    input  logic [1:0]      ctl_code,
    input  logic            ctl_pol,
    input  logic            card_tick,
    input  logic            cmd_dir_req,
    input  logic            dat_dir_req,
    output logic [7:0]      rd_data,
    output logic            card_clk_en,
    output logic            pad_hold,
    output logic            pad_clk_lvl,
    output logic            pad_cmd_lvl,
    output logic [NDAT-1:0] pad_dat_lvl,
    output logic            host_ready,
    output logic            dir_cmd,
    output logic            dir_dat
);
    pstate_e    state;
    logic       pol;
    logic       warm_done;
    logic [1:0] code;

    cpwr_state_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_code  (ctl_code),
        .ctl_pol   (ctl_pol),
        .warm_done (warm_done),
        .state     (state),
        .pol       (pol)
    );

    cpwr_warm_timer #(.WARM_CYCLES(WARM_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == PS_WARM),
        .tick (card_tick),
        .done (warm_done)
    );

    cpwr_pad_drive #(.NDAT(NDAT)) u_pads (
        .state       (state),
        .pol         (pol),
        .cmd_dir_req (cmd_dir_req),
        .dat_dir_req (dat_dir_req),
        .code        (code),
        .card_clk_en (card_clk_en),
        .pad_hold    (pad_hold),
        .pad_clk_lvl (pad_clk_lvl),
        .pad_cmd_lvl (pad_cmd_lvl),
        .pad_dat_lvl (pad_dat_lvl),
        .host_ready  (host_ready),
        .dir_cmd     (dir_cmd),
        .dir_dat     (dir_dat)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[1:0]     = code;
        rd_data[POL_BIT] = pol;
    end

endmodule

// File: rtl/cpwr_checker.sv
module cpwr_checker #(
    parameter int NDAT        = 8,
    parameter int WARM_CYCLES = 74
) (
    input logic            clk,
    input logic            rst,
    input logic            ctl_wr,
    input logic [1:0]      ctl_code,
    input logic            card_tick,
    input logic [7:0]      rd_data,
    input logic            card_clk_en,
    input logic            pad_hold,
    input logic            pad_clk_lvl,
    input logic            pad_cmd_lvl,
    input logic [NDAT-1:0] pad_dat_lvl,
    input logic            host_ready,
    input logic            dir_cmd,
    input logic            dir_dat
);
    localparam int CW = $clog2(WARM_CYCLES + 2);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || rd_data[1:0] != 2'b11 || host_ready) begin
            seen <= '0;
        end else if (card_tick) begin
            seen <= seen + 1'b1;
        end
    end

    assert_reset_state_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == 8'h00 && !card_clk_en && pad_hold &&
                        !pad_clk_lvl && !pad_cmd_lvl && pad_dat_lvl == '0 && !host_ready));

    assert_cycle_low_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_data[1:0] == 2'b10) |-> (!pad_clk_lvl && !pad_cmd_lvl &&
                                      pad_dat_lvl == '0 && pad_hold && !card_clk_en));

    assert_off_high_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_data[1:0] == 2'b00 && pad_cmd_lvl) |-> (pad_clk_lvl && (&pad_dat_lvl) &&
                                                     pad_hold && !card_clk_en && !host_ready));

    assert_ready_in_on_R6: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (rd_data[1:0] == 2'b11 && card_clk_en && !pad_hold));

    assert_window_length_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ready) |-> (seen == CW'(WARM_CYCLES)));

    assert_reserved_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_code == 2'b01) |=> $stable(rd_data));

    assert_dir_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !host_ready |-> (dir_cmd != rd_data[4] && dir_dat != rd_data[4]));

    assert_stop_immediate_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_code[0]) |=> (!host_ready && !card_clk_en));

endmodule

bind card_pwr_ctrl cpwr_checker #(.NDAT(NDAT), .WARM_CYCLES(WARM_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_code    (ctl_code),
    .card_tick   (card_tick),
    .rd_data     (rd_data),
    .card_clk_en (card_clk_en),
    .pad_hold    (pad_hold),
    .pad_clk_lvl (pad_clk_lvl),
    .pad_cmd_lvl (pad_cmd_lvl),
    .pad_dat_lvl (pad_dat_lvl),
    .host_ready  (host_ready),
    .dir_cmd     (dir_cmd),
    .dir_dat     (dir_dat)
);

// File: tb/sim_card_pwr_ctrl.sv
`timescale 1ns/100ps
module sim_card_pwr_ctrl;
    localparam int NDAT = 8;
    localparam int WARM = 74;

    logic clk = 1'b0, rst = 1'b1, ctl_wr = 1'b0, ctl_pol = 1'b0;
    logic [1:0] ctl_code = 2'b00;
    logic card_tick = 1'b0, cmd_dir_req = 1'b0, dat_dir_req = 1'b0;
    logic [7:0] rd_data;
    logic card_clk_en, pad_hold, pad_clk_lvl, pad_cmd_lvl, host_ready, dir_cmd, dir_dat;
    logic [NDAT-1:0] pad_dat_lvl;

    card_pwr_ctrl #(.NDAT(NDAT), .WARM_CYCLES(WARM)) u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_code(ctl_code), .ctl_pol(ctl_pol),
        .card_tick(card_tick), .cmd_dir_req(cmd_dir_req), .dat_dir_req(dat_dir_req),
        .rd_data(rd_data), .card_clk_en(card_clk_en), .pad_hold(pad_hold),
        .pad_clk_lvl(pad_clk_lvl), .pad_cmd_lvl(pad_cmd_lvl), .pad_dat_lvl(pad_dat_lvl),
        .host_ready(host_ready), .dir_cmd(dir_cmd), .dir_dat(dir_dat)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cycles = 0, tick_mode = 0, tick_ph = 0;
    bit live = 0, over = 0;
    // model state: 0 reset, 1 off, 2 power-cycle, 3 warm-up, 4 on
    int mstate = 0, mcnt = 0;
    bit mpol = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!over) begin
            over = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // behavioural reference, advanced at every edge
    always @(posedge clk) begin
        if (rst) begin
            mstate = 0; mcnt = 0; mpol = 0; live = 1;
        end else if (ctl_wr && ctl_code != 2'b01 && ctl_code != 2'b11) begin
            mpol = ctl_pol;
            mstate = (ctl_code == 2'b00) ? 1 : 2;
        end else begin
            if (ctl_wr && ctl_code == 2'b11) mpol = ctl_pol;
            if (ctl_wr && ctl_code == 2'b11 && mstate < 3) begin
                mstate = 3; mcnt = 0;
            end else if (mstate == 3 && card_tick) begin
                mcnt++;
                if (mcnt == WARM) mstate = 4;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        tick_ph++;
        card_tick = (tick_mode == 1) || (tick_mode == 3 && (tick_ph % 3) == 0);
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (live && !over) begin
            string tag;
            logic [1:0] code;
            logic lvl, clkl;
            tag  = (mstate == 0) ? "R2" : (mstate == 1) ? "R4" : (mstate == 2) ? "R3" :
                   (mstate == 3) ? "R5" : "R6";
            code = (mstate == 2) ? 2'b10 : (mstate >= 3) ? 2'b11 : 2'b00;
            lvl  = (mstate == 1 || mstate >= 3);
            clkl = (mstate == 1);
            chk(rd_data == {3'b0, mpol, 2'b0, code}, "R1", "rd_data", rd_data, {3'b0, mpol, 2'b0, code});
            chk(card_clk_en == (mstate >= 3), tag, "card_clk_en", card_clk_en, mstate >= 3);
            chk(pad_hold == (mstate != 4), tag, "pad_hold", pad_hold, mstate != 4);
            chk(host_ready == (mstate == 4), tag, "host_ready", host_ready, mstate == 4);
            chk(pad_clk_lvl == clkl, tag, "pad_clk_lvl", pad_clk_lvl, clkl);
            chk(pad_cmd_lvl == lvl, tag, "pad_cmd_lvl", pad_cmd_lvl, lvl);
            chk(pad_dat_lvl == {NDAT{lvl}}, tag, "pad_dat_lvl", pad_dat_lvl, {NDAT{lvl}});
            chk(dir_cmd == (((mstate == 4) ? cmd_dir_req : 1'b1) ^ mpol), "R8", "dir_cmd",
                dir_cmd, ((mstate == 4) ? cmd_dir_req : 1'b1) ^ mpol);
            chk(dir_dat == (((mstate == 4) ? dat_dir_req : 1'b1) ^ mpol), "R8", "dir_dat",
                dir_dat, ((mstate == 4) ? dat_dir_req : 1'b1) ^ mpol);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !over) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R6 actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    task automatic wr(input logic [1:0] code, input logic pol);
        @(posedge clk); #1;
        ctl_wr = 1; ctl_code = code; ctl_pol = pol;
        @(posedge clk); #1;
        ctl_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        idle(3);
        rst = 0;
        #1;
        chk(rd_data == 8'h00 && pad_hold && pad_dat_lvl == '0 && !card_clk_en, "R2",
            "reset state", {rd_data, pad_dat_lvl}, 16'h0000);

        wr(2'b10, 0);
        chk(rd_data[1:0] == 2'b10 && pad_dat_lvl == '0 && !pad_clk_lvl, "R3", "cycle pads",
            {rd_data, pad_dat_lvl}, {8'h02, 8'h00});
        idle(3);
        wr(2'b00, 0);
        chk(pad_dat_lvl == '1 && pad_cmd_lvl && pad_clk_lvl, "R4", "off pads", pad_dat_lvl, 8'hff);

        tick_mode = 1;
        wr(2'b11, 0);
        chk(card_clk_en && pad_hold && !host_ready, "R5", "warm entry",
            {card_clk_en, pad_hold, host_ready}, 3'b110);
        idle(WARM - 3);
        chk(!host_ready, "R6", "ready not early", host_ready, 0);
        idle(6);
        chk(host_ready && !pad_hold, "R6", "ready after window", {host_ready, pad_hold}, 2'b10);

        wr(2'b01, 1);
        chk(rd_data == 8'h03 && host_ready, "R7", "reserved write ignored", rd_data, 8'h03);
        wr(2'b11, 1);
        chk(host_ready && rd_data == 8'h13, "R6", "on write in on keeps ready", rd_data, 8'h13);
        cmd_dir_req = 1; dat_dir_req = 0;
        idle(2);
        chk(dir_cmd == 0 && dir_dat == 1, "R8", "inverted directions", {dir_cmd, dir_dat}, 2'b01);

        wr(2'b00, 0);
        chk(!host_ready && !card_clk_en, "R9", "off from on", host_ready, 0);

        tick_mode = 3;
        wr(2'b11, 0);
        idle(20);
        wr(2'b10, 0);
        chk(rd_data[1:0] == 2'b10 && !card_clk_en, "R9", "abort warm-up", rd_data, 8'h02);

        wr(2'b11, 0);
        idle(30);
        wr(2'b01, 1);
        chk(rd_data == 8'h03 && !host_ready, "R7", "reserved write in warm-up", rd_data, 8'h03);
        wr(2'b11, 0);
        idle(3 * WARM);
        chk(host_ready, "R6", "ready with sparse ticks", host_ready, 1);

        rst = 1;
        idle(2);
        rst = 0;
        #1;
        chk(rd_data == 8'h00 && !host_ready && !pad_cmd_lvl, "R2", "reset from on",
            rd_data, 8'h00);
        idle(3);
        finish_run();
    end
endmodule